// File: doc/BRIEF.md
# Ring Bus Mediator Sequencer

This block is the clock-owning node of a ring bus in which every member forwards a data line and a clock line to its neighbour. At rest the sequencer holds the bus clock and its data output high. A low level arriving on its data input from the ring means that some node wants the bus. The sequencer answers by holding the bus clock low for a programmable arbitration window. It then toggles the clock at a programmable half-period and, while it does so, passes the ring data along or drives its own bit.

A member ends a message, or rescues the bus, by no longer forwarding the clock. The sequencer sees the returned clock stuck high. It then freezes the bus clock high and toggles the data line to form an interjection. Next it clocks two control-bit cycles and one closing cycle. If the data line is low at the closing rising edge, a new arbitration begins at once. All timing is counted in cycles where the `tick` strobe is high.

Top module: `ring_med_seq`

## Requirements
- R1: While idle, `bus_clk` is high. `dout` is low exactly while `tx_req` is high and is high otherwise.
- R2: A low `din` seen while idle starts arbitration. `bus_clk` goes low for exactly LONG_TICKS ticks and then rises.
- R3: During arbitration, `dout` is low only if `tx_req` was high in the cycle arbitration began. A low `din` is never copied to `dout`, and a later change of `tx_req` has no effect.
- R4: After arbitration, `bus_clk` alternates HALF_TICKS ticks high and HALF_TICKS ticks low. `dout` equals `tx_data` when the sequencer won arbitration with its own request, and equals `din` otherwise.
- R5: If the synchronized `clkin` stays high with no change for 2*HALF_TICKS ticks during transmission, `bus_clk` is held high. While it is held, `dout` makes PULSES pulses, each HALF_TICKS ticks low followed by HALF_TICKS ticks high. With the defaults and the stall applied just after a rising edge, the held-high stretch lasts 36 cycles.
- R6: After the interjection, `bus_clk` runs three cycles, each HALF_TICKS ticks low then HALF_TICKS ticks high. `dout` forwards `din` during the first two cycles (the control bits) and is driven high during the third.
- R7: If the synchronized `din` is low at the third rising edge of R6, `bus_clk` falls again after HALF_TICKS high ticks and a new arbitration of LONG_TICKS ticks follows. Otherwise the sequencer stays idle.
- R8: Timers advance only in cycles with `tick` high. Outside idle, `bus_clk` does not change in a cycle without `tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Timebase strobe; every timer counts only these cycles |
| din | input | 1 | Data line arriving from the ring |
| clkin | input | 1 | Clock line returned from the ring |
| tx_req | input | 1 | Local request to win the bus |
| tx_data | input | 1 | Local data bit driven while the sequencer owns the bus |
| bus_clk | output | 1 | Bus clock driven into the ring |
| dout | output | 1 | Data line driven into the ring |

## Verification
The bench checks the length of every bus clock segment, so a timer that is off by one, or an arbitration window stretched by idle strobe cycles, shows up as a wrong length. It stalls the returned clock right after a rising edge and expects a 36-cycle high stretch containing exactly four data pulses. A detector that fires early, late, or on the wrong level changes either that length or the pulse count. It holds the data input low through the control bits and expects the forwarded low, then a forced high in the closing cycle, then an immediate 20-cycle rearbitration. A sequencer that keeps forwarding, or that returns to idle, fails there. It also drops the local request during arbitration and expects the data output to stay low. It drives a low ring input while the sequencer transmits its own bit and expects that input to be ignored.

// File: rtl/ring_med_pkg.sv
package ring_med_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ARB  = 3'd1,
    ST_RUN  = 3'd2,
    ST_INTJ = 3'd3,
    ST_CTRL = 3'd4
  } med_state_e;

  // control section: two control-bit cycles plus the closing cycle, two halves each
  localparam int CTRL_HALVES = 6;
endpackage

// File: rtl/ring_med_rstsync.sv
module ring_med_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= 2'b00;
    else         chain_q <= {chain_q[0], 1'b1};
  end

  assign rst_n_o = chain_q[1];
endmodule

// File: rtl/ring_med_sync.sv
module ring_med_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_single
      assign sh_d = d;
    end else begin : g_chain
      assign sh_d = {sh_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/ring_med_timer.sv
module ring_med_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expire
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                     cnt_d = load_val;
    else if (tick && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = tick && (cnt_q == '0);
endmodule

// File: rtl/ring_med_stall.sv
module ring_med_stall #(
  parameter int HALF_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  input  logic fb,
  output logic stall
);
  localparam int LIM = 2 * HALF_TICKS;
  localparam int CW  = $clog2(LIM + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          fb_q;

  always_comb begin
    cnt_d = cnt_q;
    if (!en || fb != fb_q)                  cnt_d = '0;
    else if (tick && cnt_q != CW'(LIM))     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      fb_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      fb_q  <= fb;
    end
  end

  assign stall = tick && en && fb && (cnt_q == CW'(LIM));
endmodule

// File: rtl/ring_med_seq.sv
module ring_med_seq
  import ring_med_pkg::*;
#(
  parameter int HALF_TICKS  = 4,
  parameter int LONG_TICKS  = 20,
  parameter int PULSES      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic din,
  input  logic clkin,
  input  logic tx_req,
  input  logic tx_data,
  output logic bus_clk,
  output logic dout
);
  localparam int MAXT      = (LONG_TICKS > HALF_TICKS) ? LONG_TICKS : HALF_TICKS;
  localparam int TW        = $clog2(MAXT + 1);
  localparam int PH_RAW    = $clog2(2 * PULSES + 1);
  localparam int PH_W      = (PH_RAW > 3) ? PH_RAW : 3;
  localparam int LAST_PULS = 2 * PULSES - 1;
  localparam int LAST_CTRL = CTRL_HALVES - 1;
  localparam int EDGE_CTRL = CTRL_HALVES - 2;

  logic rst_i_n, din_s, clkin_s, expire, stall;
  logic ld;
  logic [TW-1:0] ld_val;

  med_state_e      state_q, state_d;
  logic            clk_q, clk_d;
  logic            own_q, own_d;
  logic            pulse_q, pulse_d;
  logic            rearm_q, rearm_d;
  logic [PH_W-1:0] ph_q, ph_d;

  ring_med_rstsync u_rst (.clk(clk), .arst_n(rst_n), .rst_n_o(rst_i_n));

  ring_med_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_din (
    .clk(clk), .rst_n(rst_i_n), .d(din), .q(din_s));

  ring_med_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_clk (
    .clk(clk), .rst_n(rst_i_n), .d(clkin), .q(clkin_s));

  ring_med_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_i_n), .tick(tick), .load(ld), .load_val(ld_val),
    .expire(expire));

  ring_med_stall #(.HALF_TICKS(HALF_TICKS)) u_stall (
    .clk(clk), .rst_n(rst_i_n), .tick(tick), .en(state_q == ST_RUN),
    .fb(clkin_s), .stall(stall));

  // next-state logic
  always_comb begin
    state_d = state_q;
    clk_d   = clk_q;
    own_d   = own_q;
    pulse_d = pulse_q;
    rearm_d = rearm_q;
    ph_d    = ph_q;
    ld      = 1'b0;
    ld_val  = TW'(HALF_TICKS - 1);
    unique case (state_q)
      ST_IDLE: begin
        clk_d = 1'b1;
        if (!din_s) begin
          state_d = ST_ARB;
          clk_d   = 1'b0;
          own_d   = tx_req;
          ld      = 1'b1;
          ld_val  = TW'(LONG_TICKS - 1);
        end
      end
      ST_ARB: begin
        if (expire) begin
          state_d = ST_RUN;
          clk_d   = 1'b1;
          ld      = 1'b1;
        end
      end
      ST_RUN: begin
        if (stall) begin
          state_d = ST_INTJ;
          clk_d   = 1'b1;
          pulse_d = 1'b0;
          ph_d    = '0;
          ld      = 1'b1;
        end else if (expire) begin
          clk_d = ~clk_q;
          ld    = 1'b1;
        end
      end
      ST_INTJ: begin
        if (expire) begin
          ld = 1'b1;
          if (ph_q == PH_W'(LAST_PULS)) begin
            state_d = ST_CTRL;
            clk_d   = 1'b0;
            pulse_d = 1'b1;
            ph_d    = '0;
          end else begin
            pulse_d = ~pulse_q;
            ph_d    = ph_q + 1'b1;
          end
        end
      end
      ST_CTRL: begin
        if (expire) begin
          if (ph_q == PH_W'(LAST_CTRL)) begin
            if (rearm_q) begin
              state_d = ST_ARB;
              clk_d   = 1'b0;
              own_d   = tx_req;
              ld      = 1'b1;
              ld_val  = TW'(LONG_TICKS - 1);
            end else begin
              state_d = ST_IDLE;
              clk_d   = 1'b1;
            end
          end else begin
            ph_d  = ph_q + 1'b1;
            clk_d = ~clk_q;
            ld    = 1'b1;
            if (ph_q == PH_W'(EDGE_CTRL)) rearm_d = ~din_s;
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
        clk_d   = 1'b1;
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      clk_q   <= 1'b1;
      own_q   <= 1'b0;
      pulse_q <= 1'b1;
      rearm_q <= 1'b0;
      ph_q    <= '0;
    end else begin
      state_q <= state_d;
      clk_q   <= clk_d;
      own_q   <= own_d;
      pulse_q <= pulse_d;
      rearm_q <= rearm_d;
      ph_q    <= ph_d;
    end
  end

  // data output: ring shoot-through where forwarding applies
  always_comb begin
    unique case (state_q)
      ST_IDLE: dout = ~tx_req;
      ST_ARB:  dout = ~own_q;
      ST_RUN:  dout = own_q ? tx_data : din;
      ST_INTJ: dout = pulse_q;
      ST_CTRL: dout = (ph_q >= PH_W'(EDGE_CTRL)) ? 1'b1 : din;
      default: dout = 1'b1;
    endcase
  end

  assign bus_clk = clk_q;
endmodule

// File: rtl/ring_med_chk.sv
module ring_med_chk
  import ring_med_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       bus_clk,
  input med_state_e st
);
  // R1: the bus clock rests high whenever the sequencer is idle
  a_r1_idle_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> bus_clk);

  // R2: the arbitration window holds the bus clock low
  a_r2_arb_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ARB) |-> !bus_clk);

  // R5: the clock is frozen high throughout the interjection
  a_r5_intj_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_INTJ) |-> bus_clk);

  // R6: leaving the interjection opens the first control cycle with a falling clock
  a_r6_ctrl_opens_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_INTJ && st == ST_CTRL) |-> !bus_clk);

  // R7: an immediate rearbitration follows a high closing half
  a_r7_rearm_from_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_CTRL && st == ST_ARB) |-> ($past(bus_clk) && !bus_clk));

  // R8: without a tick the bus clock cannot move outside idle
  a_r8_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && st != ST_IDLE) |=> $stable(bus_clk));
endmodule

bind ring_med_seq ring_med_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bus_clk(bus_clk), .st(state_q));

// File: tb/tb_ring_med_seq.sv
`timescale 1ns/1ps
module tb_ring_med_seq;
  logic clk, rst_n, tick, din, tx_req, tx_data, stall_drv;
  logic bus_clk, dout, clkin;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  typedef struct {
    logic  lvl;
    int    len;
    int    falls;
    string req;
  } seg_t;
  seg_t exp_q[$];

  assign clkin = stall_drv ? 1'b1 : bus_clk;

  ring_med_seq dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .din(din), .clkin(clkin),
    .tx_req(tx_req), .tx_data(tx_data), .bus_clk(bus_clk), .dout(dout));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic push_seg(input logic lvl, input int len, input int falls,
                          input string req);
    seg_t s;
    s.lvl = lvl; s.len = len; s.falls = falls; s.req = req;
    exp_q.push_back(s);
  endtask

  // monitor: closes each bus clock segment and compares it with the scoreboard
  bit   mon_en = 0;
  logic prev_clk, prev_dout;
  int   seg_len, seg_falls;
  always @(negedge clk) begin
    if (mon_en) begin
      if (bus_clk !== prev_clk) begin
        n_checks++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL unexpected bus_clk edge: actual level %0b len %0d, expected none",
                   prev_clk, seg_len);
        end else begin
          seg_t e;
          e = exp_q.pop_front();
          if (e.lvl !== prev_clk || (e.len >= 0 && e.len != seg_len) ||
              (e.falls >= 0 && e.falls != seg_falls)) begin
            n_fail++;
            $display("FAIL %s segment: actual level %0b len %0d falls %0d, expected level %0b len %0d falls %0d",
                     e.req, prev_clk, seg_len, seg_falls, e.lvl, e.len, e.falls);
          end
        end
        seg_len   = 1;
        seg_falls = 0;
        prev_clk  = bus_clk;
      end else begin
        seg_len++;
        if (bus_clk && prev_dout && !dout) seg_falls++;
      end
      prev_dout = dout;
    end
  end

  task automatic nclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b1; din = 1'b1; tx_req = 1'b0; tx_data = 1'b1;
    stall_drv = 1'b0;
    nclk(5);
    rst_n = 1'b1;
    nclk(5);
    check("R1", "idle bus_clk", bus_clk, 1'b1);
    check("R1", "idle dout", dout, 1'b1);
    tx_req = 1'b1;
    nclk(1);
    check("R1", "dout with local request", dout, 1'b0);
    tx_req = 1'b0;
    nclk(1);
    check("R1", "dout after request drops", dout, 1'b1);
    prev_clk = bus_clk; prev_dout = dout; seg_len = 1; seg_falls = 0;
    mon_en = 1;

    // S1: member request, stall on the third rising edge, return to idle
    push_seg(1'b1, -1, -1, "R1");
    push_seg(1'b0, 20, -1, "R2");
    for (int i = 0; i < 3; i++) begin
      push_seg(1'b1, 4, -1, "R4");
      push_seg(1'b0, 4, -1, "R4");
    end
    push_seg(1'b1, 36, 4, "R5");
    for (int i = 0; i < 2; i++) begin
      push_seg(1'b0, 4, -1, "R6");
      push_seg(1'b1, 4, -1, "R6");
    end
    push_seg(1'b0, 4, -1, "R6");
    din = 1'b0;
    @(negedge bus_clk);
    nclk(5);
    check("R3", "low din not copied in arbitration", dout, 1'b1);
    din = 1'b1;
    @(posedge bus_clk);
    nclk(1);
    din = 1'b0;
    nclk(1);
    check("R4", "din forwarded while member transmits", dout, 1'b0);
    din = 1'b1;
    @(posedge bus_clk);
    @(posedge bus_clk);
    nclk(1);
    stall_drv = 1'b1;
    @(negedge bus_clk);
    @(negedge bus_clk);
    nclk(1);
    stall_drv = 1'b0;
    check("R6", "control bit forwards high din", dout, 1'b1);
    for (int i = 0; i < 3; i++) @(posedge bus_clk);
    nclk(12);
    check("R7", "stays idle with din high", bus_clk, 1'b1);
    check("R1", "dout high back in idle", dout, 1'b1);

    // S2: own request, tick gap, stall on first rise, rearbitration
    push_seg(1'b1, -1, -1, "R1");
    push_seg(1'b0, 50, -1, "R8");
    push_seg(1'b1, 4, -1, "R4");
    push_seg(1'b0, 4, -1, "R4");
    push_seg(1'b1, 36, 4, "R5");
    for (int i = 0; i < 2; i++) begin
      push_seg(1'b0, 4, -1, "R6");
      push_seg(1'b1, 4, -1, "R6");
    end
    push_seg(1'b0, 4, -1, "R6");
    push_seg(1'b1, 4, -1, "R7");
    push_seg(1'b0, 20, -1, "R7");
    push_seg(1'b1, 4, -1, "R4");
    push_seg(1'b0, 4, -1, "R4");
    push_seg(1'b1, 36, 4, "R5");
    for (int i = 0; i < 2; i++) begin
      push_seg(1'b0, 4, -1, "R6");
      push_seg(1'b1, 4, -1, "R6");
    end
    push_seg(1'b0, 4, -1, "R6");
    tx_req = 1'b1;
    din    = 1'b0;
    nclk(1);
    check("R1", "own request pulls dout low", dout, 1'b0);
    @(negedge bus_clk);
    nclk(1);
    tick   = 1'b0;
    tx_req = 1'b0;
    nclk(15);
    check("R3", "own request latched at arbitration start", dout, 1'b0);
    check("R8", "clock held low without tick", bus_clk, 1'b0);
    nclk(15);
    tick = 1'b1;
    @(posedge bus_clk);
    nclk(1);
    stall_drv = 1'b1;
    tx_data   = 1'b0;
    nclk(1);
    check("R4", "own data driven", dout, 1'b0);
    tx_data = 1'b1;
    nclk(1);
    check("R4", "low din ignored while own data is driven", dout, 1'b1);
    @(negedge bus_clk);
    @(negedge bus_clk);
    nclk(1);
    stall_drv = 1'b0;
    check("R6", "control bit forwards low din", dout, 1'b0);
    @(negedge bus_clk);
    @(negedge bus_clk);
    nclk(1);
    check("R6", "closing cycle drives dout high", dout, 1'b1);
    @(negedge bus_clk);
    nclk(2);
    check("R3", "rearbitration without own request", dout, 1'b1);
    check("R7", "rearbitration clock low", bus_clk, 1'b0);
    din = 1'b1;
    @(posedge bus_clk);
    nclk(1);
    stall_drv = 1'b1;
    @(negedge bus_clk);
    @(negedge bus_clk);
    nclk(1);
    stall_drv = 1'b0;
    for (int i = 0; i < 3; i++) @(posedge bus_clk);
    nclk(12);
    check("R7", "idle after closing edge with din high", bus_clk, 1'b1);
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R6 scoreboard: actual %0d segments left, expected 0", exp_q.size());
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule